// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits behind the inbound write path of a host-side bridge. Every inbound memory write is presented as a one-cycle strobe with a 64-bit address and a 32-bit data word. When the address equals a programmable 64-bit capture address, the write is taken as an interrupt message. The low byte of its data is a vector number, and the block records that vector as pending. Vectors are handed out to functions in aligned power-of-two groups, so the data word already holds the group base plus the offset inside the group. It is decoded as a flat vector index and nothing more.

Pending state lives in banks of 32 vectors, eight banks by default. Each bank has an enable word, a mask word and a pending-status word. Software reaches these, and the two halves of the capture address, through a simple register port with a one-cycle read latency. Pending bits are cleared by writing ones. A single registered interrupt line tells the host that at least one vector is enabled, unmasked and pending.

Top module: `msi_capture_top`

## Requirements
- R1: After synchronous reset every register reads zero, `irq_out` is low and `reg_rdata` is zero.
- R2: The capture address low half is read and written at offset 0x820 and the high half at offset 0x824. A read returns the value last written.
- R3: An inbound write whose 64-bit address equals the capture address sets pending bit v%32 of bank v/32, where v is the vector. An inbound write to any other address changes no pending bit.
- R4: A message for vector v sets the pending bit only if enable bit v%32 of bank v/32 was 1 before that clock edge.
- R5: For the status word, a 1 written to a bit clears that pending bit and a 0 leaves it unchanged. A register write never sets a pending bit.
- R6: Bank n has its enable word at 0x828+12n, its mask word at 0x82C+12n and its status word at 0x830+12n. The enable and mask words read back what was written. Read data appears on `reg_rdata` in the cycle after `reg_re`.
- R7: `irq_out` is a register that holds the OR, over all vectors, of pending AND enabled AND NOT masked. It therefore follows a change in that condition one cycle later.
- R8: A mask bit of 1 keeps its vector out of `irq_out`, but a message still records the pending bit.
- R9: A register offset that is neither a capture address half nor an implemented bank register (for example 0x81C or 0x888) reads as zero. A write to such an offset changes no register.
- R10: When a message sets a pending bit in the same cycle that a status write clears it, the bit ends up set.
- R11: The vector is taken from data bits [7:0] only. Data bits [31:8] have no effect on which bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Inbound memory write strobe |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data; bits [7:0] carry the vector |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_re`, zero otherwise |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
Suppose a pending word becomes wrong, through a dropped set, a set that ignores its enable, or a clear that hits the wrong bit or bank. The wrong value shows up on `reg_rdata` one cycle after the affected status word is read. If the vector is enabled and unmasked, `irq_out` also goes wrong exactly one cycle after the event. A capture address that does not match correctly shows up as a missing or extra pending bit after the very next message. A decode slip between bank offsets shows as a read-back mismatch on the next read of the neighbouring word.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int unsigned REG_AW      = 12;
  localparam int unsigned BANK_BITS   = 32;
  localparam int unsigned BANK_STRIDE = 12;

  localparam int unsigned TGT_LO_OFF_I = 'h820;
  localparam int unsigned TGT_HI_OFF_I = 'h824;
  localparam int unsigned BANK0_OFF_I  = 'h828;

  localparam logic [REG_AW-1:0] TGT_LO_OFF = REG_AW'(TGT_LO_OFF_I);
  localparam logic [REG_AW-1:0] TGT_HI_OFF = REG_AW'(TGT_HI_OFF_I);

  // word kinds inside one bank, in byte-offset order
  localparam int unsigned KIND_EN   = 0;
  localparam int unsigned KIND_MASK = 1;
  localparam int unsigned KIND_STAT = 2;

  function automatic logic [REG_AW-1:0] bank_reg_off(int unsigned bank, int unsigned kind);
    return REG_AW'(BANK0_OFF_I + BANK_STRIDE * bank + 4 * kind);
  endfunction

endpackage

// File: rtl/msi_target_reg.sv
module msi_target_reg #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [ADDR_W-1:0] target,
  output logic              hit
);

  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (we_lo) lo_q <= wdata;
      if (we_hi) hi_q <= wdata;
    end
  end

  assign target = {hi_q, lo_q};
  assign hit    = (in_addr == target);

endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_we,
  input  logic          mask_we,
  input  logic          stat_we,
  input  logic [W-1:0]  wdata,
  input  logic          set_req,
  input  logic [IW-1:0] set_idx,
  output logic [W-1:0]  enable,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  status,
  output logic          pend
);

  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] status_nxt;

  always_comb begin
    set_vec    = set_req ? ((W'(1) << set_idx) & enable) : '0;
    clr_vec    = stat_we ? wdata : '0;
    // a same-cycle set overrides the write-one clear
    status_nxt = (status & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      mask   <= '0;
      status <= '0;
    end else begin
      if (en_we)   enable <= wdata;
      if (mask_we) mask   <= wdata;
      status <= status_nxt;
    end
  end

  assign pend = |(status & enable & ~mask);

endmodule

// File: rtl/msi_capture_top.sv
module msi_capture_top
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned MSG_AW   = 2 * DATA_W,
  localparam int unsigned NUM_VEC  = NUM_BANKS * BANK_BITS,
  localparam int unsigned VEC_W    = $clog2(NUM_VEC),
  localparam int unsigned BIT_IW   = $clog2(BANK_BITS),
  localparam int unsigned BANK_IW  = VEC_W - BIT_IW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [MSG_AW-1:0] msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);

  logic [MSG_AW-1:0]    target;
  logic                 addr_hit;
  logic                 msg_hit;
  logic [VEC_W-1:0]     msg_vec;
  logic [BANK_IW-1:0]   msg_bank;
  logic [BIT_IW-1:0]    msg_bit;
  logic                 unused_hi;

  logic [BANK_BITS-1:0] bank_en   [NUM_BANKS];
  logic [BANK_BITS-1:0] bank_mask [NUM_BANKS];
  logic [BANK_BITS-1:0] bank_stat [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend;

  logic [NUM_VEC-1:0]   stat_all;
  logic [NUM_VEC-1:0]   en_all;
  logic [NUM_VEC-1:0]   mask_all;

  logic [DATA_W-1:0]    rd_mux;
  logic                 irq_q;
  logic [DATA_W-1:0]    rdata_q;

  // capture address
  msi_target_reg #(.DATA_W(DATA_W)) tgt_i (
    .clk     (clk),
    .rst     (rst),
    .we_lo   (reg_we && (reg_addr == TGT_LO_OFF)),
    .we_hi   (reg_we && (reg_addr == TGT_HI_OFF)),
    .wdata   (reg_wdata),
    .in_addr (msg_addr),
    .target  (target),
    .hit     (addr_hit)
  );

  // vector decode
  assign msg_hit   = msg_valid && addr_hit;
  assign msg_vec   = msg_data[VEC_W-1:0];
  assign msg_bank  = msg_vec[VEC_W-1:BIT_IW];
  assign msg_bit   = msg_vec[BIT_IW-1:0];
  assign unused_hi = ^msg_data[DATA_W-1:VEC_W];

  // pending banks
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_en;
    logic sel_mask;
    logic sel_stat;
    logic set_here;

    assign sel_en   = reg_we && (reg_addr == bank_reg_off(b, KIND_EN));
    assign sel_mask = reg_we && (reg_addr == bank_reg_off(b, KIND_MASK));
    assign sel_stat = reg_we && (reg_addr == bank_reg_off(b, KIND_STAT));
    assign set_here = msg_hit && (msg_bank == BANK_IW'(b));

    msi_vec_bank #(.W(BANK_BITS)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .en_we   (sel_en),
      .mask_we (sel_mask),
      .stat_we (sel_stat),
      .wdata   (reg_wdata),
      .set_req (set_here),
      .set_idx (msg_bit),
      .enable  (bank_en[b]),
      .mask    (bank_mask[b]),
      .status  (bank_stat[b]),
      .pend    (bank_pend[b])
    );

    assign stat_all[b*BANK_BITS +: BANK_BITS] = bank_stat[b];
    assign en_all[b*BANK_BITS +: BANK_BITS]   = bank_en[b];
    assign mask_all[b*BANK_BITS +: BANK_BITS] = bank_mask[b];
  end

  // register read path
  always_comb begin
    rd_mux = '0;
    if (reg_addr == TGT_LO_OFF) rd_mux = target[DATA_W-1:0];
    if (reg_addr == TGT_HI_OFF) rd_mux = target[MSG_AW-1:DATA_W];
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == bank_reg_off(b, KIND_EN))   rd_mux = bank_en[b];
      if (reg_addr == bank_reg_off(b, KIND_MASK)) rd_mux = bank_mask[b];
      if (reg_addr == bank_reg_off(b, KIND_STAT)) rd_mux = bank_stat[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= reg_re ? rd_mux : '0;
      irq_q   <= |bank_pend;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = irq_q;

endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NUM_VEC  = NUM_BANKS * BANK_BITS
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_valid,
  input logic               reg_we,
  input logic               reg_re,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_out,
  input logic [NUM_VEC-1:0] stat_all,
  input logic [NUM_VEC-1:0] en_all,
  input logic [NUM_VEC-1:0] mask_all
);

  localparam logic [REG_AW-1:0] LAST_OFF = bank_reg_off(NUM_BANKS - 1, KIND_STAT);

  // R7: summary line follows the qualifying condition one cycle later
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(stat_all & en_all & ~mask_all))));

  // R4: no pending bit rises for a vector that was disabled
  p_set_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(en_all)) == '0));

  // R3: pending bits rise only from an inbound write, one at a time
  p_set_only_msg_r3: assert property (@(posedge clk) disable iff (rst)
    !msg_valid |=> ((stat_all & ~$past(stat_all)) == '0));

  p_one_set_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(stat_all & ~$past(stat_all)) <= 1));

  // R5: pending bits fall only through a register write
  p_clear_by_write_r5: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> ((~stat_all & $past(stat_all)) == '0));

  // R9: unimplemented offsets read zero
  p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_re && ((reg_addr < TGT_LO_OFF) || (reg_addr > LAST_OFF))) |=> (reg_rdata == '0));

  // R6: read data is zero when no read was issued
  p_rdata_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> (reg_rdata == '0));

endmodule

bind msi_capture_top msi_capture_chk #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .stat_all  (stat_all),
  .en_all    (en_all),
  .mask_all  (mask_all)
);

// File: tb/msi_capture_top_tb_top.sv
`timescale 1ns/1ps
module msi_capture_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

  always #2 clk = ~clk;

  msi_capture_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send_msg(logic [63:0] a, logic [31:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    reg_read(12'h820, d); check("R1 addr lo", d, 32'h0);
    reg_read(12'h828, d); check("R1 enable0", d, 32'h0);
    reg_read(12'h884, d); check("R1 status7", d, 32'h0);
  endtask

  task automatic t_target;
    logic [31:0] d;
    reg_write(12'h820, TGT[31:0]);
    reg_write(12'h824, TGT[63:32]);
    reg_read(12'h820, d); check("R2 lo", d, TGT[31:0]);
    reg_read(12'h824, d); check("R2 hi", d, TGT[63:32]);
  endtask

  task automatic t_bank_regs;
    logic [31:0] d;
    reg_write(12'h840, 32'h1234_5678);
    reg_write(12'h868, 32'h0F0F_0000);
    reg_read(12'h840, d); check("R6 enable2", d, 32'h1234_5678);
    reg_read(12'h868, d); check("R6 mask5", d, 32'h0F0F_0000);
    reg_read(12'h844, d); check("R6 mask2 separate", d, 32'h0);
    reg_write(12'h830, 32'hFFFF_FFFF);
    reg_read(12'h830, d); check("R5 write never sets", d, 32'h0);
    reg_write(12'h840, 32'h0);
    reg_write(12'h868, 32'h0);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    reg_write(12'h828, 32'hFFFF_FFFF);
    send_msg(TGT, 32'd5);
    check("R7 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R7 irq one cycle later", {31'b0, irq_out}, 32'h1);
    reg_read(12'h830, d); check("R3 bit5 bank0", d, 32'h0000_0020);
    reg_write(12'h830, 32'h0);
    reg_read(12'h830, d); check("R5 zero write keeps", d, 32'h0000_0020);
    reg_write(12'h830, 32'h0000_0020);
    check("R7 irq holds one cycle", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R7 irq drops", {31'b0, irq_out}, 32'h0);
    reg_read(12'h830, d); check("R5 cleared", d, 32'h0);
    // aligned group base 0x40 plus offset 3
    reg_write(12'h840, 32'hFFFF_FFFF);
    send_msg(TGT, 32'h43);
    reg_read(12'h848, d); check("R3 vector 0x43 bank2", d, 32'h0000_0008);
    reg_write(12'h848, 32'hFFFF_FFFF);
    // mismatching addresses
    send_msg(TGT ^ 64'h0000_0002_0000_0000, 32'd5);
    send_msg(TGT + 64'd4, 32'd5);
    idle(1);
    check("R3 no irq on miss", {31'b0, irq_out}, 32'h0);
    reg_read(12'h830, d); check("R3 miss ignored", d, 32'h0);
    reg_write(12'h828, 32'h0);
    reg_write(12'h840, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    send_msg(TGT, 32'd100);
    reg_read(12'h854, d); check("R4 disabled vector", d, 32'h0);
    check("R4 no irq", {31'b0, irq_out}, 32'h0);
    reg_write(12'h84C, 32'h0000_0010);
    send_msg(TGT, 32'd100);
    reg_read(12'h854, d); check("R4 enabled vector", d, 32'h0000_0010);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    reg_write(12'h850, 32'h0000_0010);
    idle(2);
    check("R8 masked irq low", {31'b0, irq_out}, 32'h0);
    send_msg(TGT, 32'd100);
    reg_read(12'h854, d); check("R8 still recorded", d, 32'h0000_0010);
    idle(1);
    check("R8 irq low after msg", {31'b0, irq_out}, 32'h0);
    reg_write(12'h850, 32'h0);
    check("R7 unmask not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R8 unmask raises irq", {31'b0, irq_out}, 32'h1);
    reg_write(12'h854, 32'h0000_0010);
    reg_write(12'h84C, 32'h0);
    idle(2);
    check("R7 quiet again", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_holes;
    logic [31:0] d;
    reg_write(12'h888, 32'hFFFF_FFFF);
    reg_write(12'h81C, 32'hFFFF_FFFF);
    reg_read(12'h888, d); check("R9 0x888 reads zero", d, 32'h0);
    reg_read(12'h81C, d); check("R9 0x81C reads zero", d, 32'h0);
    reg_read(12'h87C, d); check("R9 enable7 untouched", d, 32'h0);
    reg_read(12'h884, d); check("R9 status7 untouched", d, 32'h0);
    reg_read(12'h820, d); check("R9 addr lo untouched", d, TGT[31:0]);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    reg_write(12'h828, 32'hFFFF_FFFF);
    send_msg(TGT, 32'd9);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = TGT; msg_data = 32'd9;
    reg_we = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h0000_0200;
    @(negedge clk);
    msg_valid = 1'b0; reg_we = 1'b0;
    reg_read(12'h830, d); check("R10 set beats clear", d, 32'h0000_0200);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = TGT; msg_data = 32'd10;
    reg_we = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h0000_0200;
    @(negedge clk);
    msg_valid = 1'b0; reg_we = 1'b0;
    reg_read(12'h830, d); check("R10 other bit clears", d, 32'h0000_0400);
    reg_write(12'h830, 32'hFFFF_FFFF);
    reg_write(12'h828, 32'h0);
  endtask

  task automatic t_upper_data;
    logic [31:0] d;
    reg_write(12'h828, 32'h0000_0040);
    send_msg(TGT, 32'hABCD_0106);
    reg_read(12'h830, d); check("R11 upper data ignored", d, 32'h0000_0040);
    reg_read(12'h834, d); check("R11 bank1 untouched", d, 32'h0);
    reg_write(12'h830, 32'h0000_0040);
    reg_write(12'h828, 32'h0);
    idle(2);
    check("R7 final irq low", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_target();
    t_bank_regs();
    t_capture();
    t_enable();
    t_mask();
    t_holes();
    t_set_wins();
    t_upper_data();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule